// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Sixteenth-Bit Stop Control

This block serialises characters onto a single line for an asynchronous serial link. It runs from the system clock and advances only on a one-cycle enable at sixteen times the bit rate, so each bit lasts 16 enable pulses. A character of 5 to 8 data bits goes out least significant bit first. It is preceded by a low start bit and may be followed by a parity slot. That slot carries even, odd, a fixed 0 or 1, or, in multidrop mode, an address/data flag supplied with the character. The stop period that closes each character can be set in sixteenths of a bit, from one bit to two bits.

Characters arrive from a buffer through a valid/ready handshake. The character's configuration is captured when it is accepted. A clear-to-send input is looked at only between characters: when it is low, no new character is taken, but a character already started always finishes. A break request forces the line low for as long as the request is held. The forcing begins only after any character in flight has fully ended, stop period included.

Top module: `utx_core`

## Requirements
- R1: After reset, and while nothing is being sent, `txd` is 1. `tx_empty` is 1 when `in_valid` is 0. `in_ready` is 1 when `cts` is 1 and `brk_req` is 0.
- R2: A character starts with one 0 bit, followed by the data bits least significant first. The data bit count is 5 + `cfg_len`, with code 0 giving 5 bits and code 3 giving 8 bits. Unused upper data bits are not sent.
- R3: The slot after the last data bit is chosen by `cfg_par`. Code 1 sends even parity, which is the XOR of the sent data bits. Code 2 sends odd parity, its inverse. Code 3 sends a constant 0 and code 4 a constant 1. Code 5 sends `in_addr` (multidrop). Codes 0, 6 and 7 send no slot.
- R4: Every start, data and parity bit lasts exactly 16 `tick16` pulses. `txd` changes only on the clock edge after a `tick16` pulse. The exceptions are the start of a character and entry to or exit from a break.
- R5: The stop period is high. For `cfg_stop` values 0 to 16 it lasts 16 + `cfg_stop` pulses. For values 17 to 31 it lasts 32 pulses.
- R6: A character is taken on a clock edge where `in_valid` and `in_ready` are both 1. The start bit appears on `txd` from the next cycle on, and `in_ready` then stays low until the character has ended.
- R7: While `cts` is 0, no character is accepted. A `cts` drop during a character does not shorten or alter that character.
- R8: `tx_empty` is 1 exactly when no character or break is in progress and `in_valid` is 0.
- R9: While `brk_req` is 1, `txd` is held at 0 and `in_ready` is 0. A character in flight completes first, including its stop period. One cycle after `brk_req` falls, `txd` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par | input | 3 | Parity slot mode code |
| cfg_stop | input | 5 | Stop period extension in 1/16 bit |
| cts | input | 1 | Clear to send, sampled between characters |
| brk_req | input | 1 | Hold line low while set |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character data |
| in_addr | input | 1 | Address/data flag for multidrop mode |
| in_ready | output | 1 | Character can be accepted |
| txd | output | 1 | Serial line output |
| tx_empty | output | 1 | Idle with nothing pending |

## Verification
Some rules hold on every cycle and are checked there. The line moves only after a tick or at a start or break transition. An accepted character produces a start bit at once and drops ready. Empty implies a high line and no pending request. Break implies a low line and no acceptance. Ready is never offered against a low clear-to-send or a pending break. Other behaviour depends on whole characters and only the bench scenarios can show it: the bit order, the parity slot contents, each stop length, and the exact tick totals. The same holds for a break or a clear-to-send drop that lands in mid-character.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int DATA_MAX      = 8;
  localparam int FRAME_W       = DATA_MAX + 2;
  localparam int NB_W          = 4;
  localparam int LEN_W         = 2;
  localparam int PAR_W         = 3;
  localparam int STOP_W        = 5;
  localparam int LIM_W         = 6;
  localparam int STOP_EXT_MAX  = TICKS_PER_BIT;

  typedef enum logic [PAR_W-1:0] {
    SLOT_NONE = 3'd0,
    SLOT_EVEN = 3'd1,
    SLOT_ODD  = 3'd2,
    SLOT_ZERO = 3'd3,
    SLOT_ONE  = 3'd4,
    SLOT_ADDR = 3'd5
  } slot_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_STOP = 2'd2,
    ST_BRK  = 2'd3
  } st_e;

  function automatic logic [NB_W-1:0] data_count(input logic [LEN_W-1:0] code);
    return NB_W'(DATA_MAX - 3) + NB_W'(code);
  endfunction

  function automatic logic slot_used(input logic [PAR_W-1:0] mode);
    return (mode >= 3'd1) && (mode <= 3'd5);
  endfunction

  function automatic logic slot_value(input logic [PAR_W-1:0] mode,
                                      input logic [DATA_MAX-1:0] sent,
                                      input logic addr);
    case (mode)
      3'd1:    return ^sent;
      3'd2:    return ~^sent;
      3'd4:    return 1'b1;
      3'd5:    return addr;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [LIM_W-1:0] stop_ticks(input logic [STOP_W-1:0] ext);
    if (ext > STOP_W'(STOP_EXT_MAX)) return LIM_W'(2 * TICKS_PER_BIT);
    return LIM_W'(TICKS_PER_BIT) + LIM_W'(ext);
  endfunction
endpackage

// File: rtl/utx_framer.sv
module utx_framer
  import utx_pkg::*;
(
  input  logic [DATA_MAX-1:0] data,
  input  logic                addr,
  input  logic [LEN_W-1:0]    len_code,
  input  logic [PAR_W-1:0]    par_mode,
  input  logic [STOP_W-1:0]   stop_ext,
  output logic [FRAME_W-1:0]  frame,
  output logic [NB_W-1:0]     nbits,
  output logic [LIM_W-1:0]    stop_lim
);
  logic [NB_W-1:0]     ndata;
  logic [DATA_MAX-1:0] kept;
  logic                slot;

  assign ndata    = data_count(len_code);
  assign stop_lim = stop_ticks(stop_ext);

  always_comb begin
    kept = '0;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < int'(ndata)) kept[i] = data[i];
  end

  assign slot = slot_value(par_mode, kept, addr);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < int'(ndata)) frame[i+1] = kept[i];
    if (slot_used(par_mode)) frame[ndata + NB_W'(1)] = slot;
  end

  assign nbits = NB_W'(1) + ndata + NB_W'(slot_used(par_mode));
endmodule

// File: rtl/utx_bitclock.sv
module utx_bitclock #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          bit_done
);
  logic [CW-1:0] cnt;

  assign bit_done = tick && !clr && (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr || bit_done)  cnt <= '0;
    else if (tick)             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/utx_seq.sv
module utx_seq
  import utx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               cts,
  input  logic               brk_req,
  input  logic [FRAME_W-1:0] frame,
  input  logic [NB_W-1:0]    nbits,
  input  logic [LIM_W-1:0]   stop_lim,
  input  logic               bit_done,
  output logic               txd,
  output logic               in_ready,
  output logic               tx_empty,
  output logic               accept,
  output logic               brk_on,
  output logic               clk_clr,
  output logic [LIM_W-1:0]   clk_limit
);
  st_e                state;
  logic [FRAME_W-1:0] sh;
  logic [NB_W-1:0]    left;
  logic [LIM_W-1:0]   stop_q;

  assign in_ready  = (state == ST_IDLE) && cts && !brk_req;
  assign accept    = in_ready && in_valid;
  assign brk_on    = (state == ST_BRK);
  assign tx_empty  = (state == ST_IDLE) && !in_valid;
  assign clk_clr   = (state == ST_IDLE) || (state == ST_BRK);
  assign clk_limit = (state == ST_STOP) ? stop_q : LIM_W'(TICKS_PER_BIT);

  always_comb begin
    case (state)
      ST_SEND: txd = sh[0];
      ST_BRK:  txd = 1'b0;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sh     <= '1;
      left   <= '0;
      stop_q <= LIM_W'(TICKS_PER_BIT);
    end else begin
      case (state)
        ST_IDLE: begin
          if (brk_req) begin
            state <= ST_BRK;
          end else if (accept) begin
            state  <= ST_SEND;
            sh     <= frame;
            left   <= nbits;
            stop_q <= stop_lim;
          end
        end
        ST_SEND: begin
          if (bit_done) begin
            if (left == NB_W'(1)) state <= ST_STOP;
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            left <= left - NB_W'(1);
          end
        end
        ST_STOP: if (bit_done) state <= ST_IDLE;
        default: if (!brk_req) state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/utx_core.sv
module utx_core
  import utx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [PAR_W-1:0]    cfg_par,
  input  logic [STOP_W-1:0]   cfg_stop,
  input  logic                cts,
  input  logic                brk_req,
  input  logic                in_valid,
  input  logic [DATA_MAX-1:0] in_data,
  input  logic                in_addr,
  output logic                in_ready,
  output logic                txd,
  output logic                tx_empty
);
  logic [FRAME_W-1:0] frame;
  logic [NB_W-1:0]    nbits;
  logic [LIM_W-1:0]   stop_lim;
  logic [LIM_W-1:0]   clk_limit;
  logic               bit_done;
  logic               clk_clr;
  logic               accept;
  logic               brk_on;

  utx_framer u_framer (
    .data     (in_data),
    .addr     (in_addr),
    .len_code (cfg_len),
    .par_mode (cfg_par),
    .stop_ext (cfg_stop),
    .frame    (frame),
    .nbits    (nbits),
    .stop_lim (stop_lim)
  );

  utx_bitclock #(.CW(LIM_W)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .clr      (clk_clr),
    .limit    (clk_limit),
    .bit_done (bit_done)
  );

  utx_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cts       (cts),
    .brk_req   (brk_req),
    .frame     (frame),
    .nbits     (nbits),
    .stop_lim  (stop_lim),
    .bit_done  (bit_done),
    .txd       (txd),
    .in_ready  (in_ready),
    .tx_empty  (tx_empty),
    .accept    (accept),
    .brk_on    (brk_on),
    .clk_clr   (clk_clr),
    .clk_limit (clk_limit)
  );
endmodule

// File: rtl/utx_core_chk.sv
module utx_core_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic cts,
  input logic brk_req,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic tx_empty,
  input logic accept,
  input logic brk_on
);
  assert_line_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txd != $past(txd)) |-> ($past(tick16) || $past(accept) || $past(brk_on) || brk_on));

  assert_start_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!txd && !in_ready && !tx_empty));

  assert_ready_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cts && !brk_req));

  assert_empty_is_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && !in_valid));

  assert_break_holds_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_on |-> (!txd && !in_ready));
endmodule

bind utx_core utx_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick16   (tick16),
  .cts      (cts),
  .brk_req  (brk_req),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .txd      (txd),
  .tx_empty (tx_empty),
  .accept   (accept),
  .brk_on   (brk_on)
);

// File: tb/sim_utx_core.sv
module sim_utx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] cfg_len = '0;
  logic [2:0] cfg_par = '0;
  logic [4:0] cfg_stop = '0;
  logic       cts = 1'b1;
  logic       brk_req = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_addr = 1'b0;
  logic       in_ready, txd, tx_empty;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) tick16 <= rst_n ? ~tick16 : 1'b0;

  utx_core u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_stop(cfg_stop), .cts(cts), .brk_req(brk_req),
    .in_valid(in_valid), .in_data(in_data), .in_addr(in_addr),
    .in_ready(in_ready), .txd(txd), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ev_kind: 0 none, 1 break request at tick ev_at, 2 cts drop at tick ev_at
  task automatic run_frame(input logic [7:0] d, input logic [1:0] lc, input logic [2:0] pm,
                           input logic a, input logic [4:0] sc, input int ev_kind, input int ev_at);
    int nlen, nb, stop_exp, total, c, si, guard, ones;
    bit has_slot, slot_bit;
    logic [9:0] exp_bits, got;
    bit stop_hi;
    nlen = 5 + int'(lc);
    has_slot = (pm != 0) && (pm < 6);
    ones = 0;
    for (int i = 0; i < nlen; i++) ones += int'(d[i]);
    case (pm)
      3'd1: slot_bit = (ones % 2) == 1;
      3'd2: slot_bit = (ones % 2) == 0;
      3'd4: slot_bit = 1'b1;
      3'd5: slot_bit = a;
      default: slot_bit = 1'b0;
    endcase
    exp_bits = '0;
    for (int i = 0; i < nlen; i++) exp_bits[i+1] = d[i];
    if (has_slot) exp_bits[nlen+1] = slot_bit;
    nb = 1 + nlen + (has_slot ? 1 : 0);
    stop_exp = (int'(sc) > 16) ? 32 : 16 + int'(sc);
    total = 16 * nb + stop_exp;

    @(negedge clk);
    cfg_len = lc; cfg_par = pm; cfg_stop = sc; in_data = d; in_addr = a; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_stop = ~sc;
    c = 0; si = 0; got = '0; stop_hi = 1'b0; guard = 0;
    while (!tx_empty && !(ev_kind == 1 && c >= total) && guard < 4000) begin
      if (si < nb && c == 16 * si + 8) begin got[si] = txd; si++; end
      if (c == 16 * nb + 2) stop_hi = txd;
      if (ev_kind == 1 && c == ev_at) brk_req = 1'b1;
      if (ev_kind == 2 && c == ev_at) cts = 1'b0;
      if (tick16) c++;
      guard++;
      @(negedge clk);
    end
    for (int i = nb; i < 10; i++) got[i] = 1'b0;
    check(got == exp_bits, "R2/R3 frame bits", int'(got), int'(exp_bits));
    check(stop_hi, "R5 stop level", int'(stop_hi), 1);
    if (ev_kind != 1)
      check(c == total, "R4/R5 frame length", c, total);
    if (ev_kind == 2) begin
      check(c == total, "R7 cts drop keeps frame", c, total);
      cts = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    check(tx_empty == 1'b1, "R1 reset empty", int'(tx_empty), 1);
    check(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3: sweep lengths, slot modes and data patterns
    for (int l = 0; l < 4; l++)
      for (int m = 0; m < 8; m++)
        for (int k = 0; k < 3; k++)
          run_frame(k == 0 ? 8'hA5 : (k == 1 ? 8'h3C : 8'hD7), 2'(l), 3'(m), k[0], 5'd0, 0, 0);

    // R5: every stop setting
    for (int s = 0; s < 32; s++) run_frame(8'h4E, 2'd3, 3'd1, 1'b0, 5'(s), 0, 0);

    // R7: cts low blocks acceptance; R8: pending character keeps empty low
    @(negedge clk);
    cts = 1'b0; in_valid = 1'b1; in_data = 8'h55;
    repeat (40) @(negedge clk);
    check(in_ready == 1'b0, "R7 cts low ready", int'(in_ready), 0);
    check(txd == 1'b1, "R7 cts low line idle", int'(txd), 1);
    check(tx_empty == 1'b0, "R8 pending not empty", int'(tx_empty), 0);
    in_valid = 1'b0;
    #0;
    check(tx_empty == 1'b1, "R8 empty after withdraw", int'(tx_empty), 1);
    cts = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R7 cts high ready", int'(in_ready), 1);

    // R7: cts dropped during a character
    run_frame(8'h9B, 2'd2, 3'd2, 1'b0, 5'd5, 2, 40);

    // R9: break requested mid-character
    run_frame(8'h6A, 2'd3, 3'd5, 1'b1, 5'd8, 1, 30);
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      check(txd == 1'b0 && in_ready == 1'b0, "R9 break holds low", int'({txd, in_ready}), 0);
      @(negedge clk);
    end
    brk_req = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R9 break release", int'(txd), 1);
    check(in_ready == 1'b1, "R9 ready after break", int'(in_ready), 1);

    // R9: break from idle
    brk_req = 1'b1;
    @(negedge clk);
    check(txd == 1'b0, "R9 idle break", int'(txd), 0);
    check(tx_empty == 1'b0, "R8 break not empty", int'(tx_empty), 0);
    brk_req = 1'b0;
    @(negedge clk);
    check(txd == 1'b1 && tx_empty == 1'b1, "R1 idle after break", int'({txd, tx_empty}), 3);

    // R6: back-to-back characters
    run_frame(8'h01, 2'd0, 3'd3, 1'b0, 5'd16, 0, 0);
    run_frame(8'hFE, 2'd1, 3'd4, 1'b0, 5'd17, 0, 0);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule